// File: doc/BRIEF.md
# Paging-Write and Walk-Path Permission Checker

This block is a second-stage permission checker placed beside a guest page walker. The walker presents one page per step: each paging-structure page it reads while translating an address, and finally the data page the translation lands on. For every step the checker weighs the kind of access against the page's read, write and execute rights and against two extra per-page controls. The first control, paging-write, lets the walker's own accessed/dirty status-bit updates land on a page that software may not write. The second control, path verification, marks a final data page as reachable only through structure pages that all carried paging-write.

Each control has its own global enable. The checker keeps one flag that records whether every structure page of the current walk carried paging-write. A walk begins on the step flagged as first. It ends on the step flagged as final. The verdict for each step is registered. It appears one cycle after the step with a valid strobe, an allow bit and a cause code.

Top module: `pgw_path_checker`

## Requirements
- R1: A step presented with `in_valid` high yields `out_valid` high on the next clock cycle only. In a cycle after no step, `out_valid` is low and `out_allow`/`out_cause` keep their previous values.
- R2: Access code 2'b00 (data read) is denied with cause 1 when read permission is clear. Access code 2'b11 (instruction fetch) is denied with cause 3 when execute permission is clear.
- R3: Access code 2'b01 (software write) is denied with cause 2 whenever write permission is clear, whatever the paging-write bit.
- R4: Access code 2'b10 (walker status-bit write) is allowed when write permission is set, or when paging-write is set and its global enable is on. Otherwise it is denied with cause 2.
- R5: With the paging-write global enable off, a page with write permission clear rejects walker status-bit writes with cause 2.
- R6: A step with `in_walk_first` high starts a new walk. The path flag used at a final step is the AND of the paging-write bits of all non-final steps since that first step. A final step that is also first sees a clean path. After a final step the flag returns to clean.
- R7: On a final step with path verification set on the page and its global enable on, the access is denied with cause 4 if the path flag is not clean. A clean path leaves only the ordinary rights checks.
- R8: With the path-verification global enable off, the page's verification bit has no effect on the verdict.
- R9: When a path failure and a rights failure both apply, cause 4 is reported.
- R10: Cause codes are 0 none, 1 read denied, 2 write denied, 3 execute denied, 4 path failed. `out_allow` is high exactly when the cause is 0.
- R11: While reset is asserted, and after it is released, the outputs are all zero and the path flag is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A page step is presented this cycle |
| in_walk_first | input | 1 | This step is the first page of a new walk |
| in_walk_final | input | 1 | This step is the final data page of the walk |
| in_acc | input | 2 | Access kind: 00 read, 01 software write, 10 walker status write, 11 fetch |
| in_perm_r | input | 1 | Page read permission |
| in_perm_w | input | 1 | Page write permission |
| in_perm_x | input | 1 | Page execute permission |
| in_pgw | input | 1 | Page paging-write control |
| in_vfy | input | 1 | Page path-verification control |
| en_pgw | input | 1 | Global enable for paging-write |
| en_vfy | input | 1 | Global enable for path verification |
| out_valid | output | 1 | Verdict strobe, one cycle after a step |
| out_allow | output | 1 | Access allowed |
| out_cause | output | 3 | Violation cause code |

## Verification
The only hidden state is the path flag. If it is wrong, the ports show nothing until the next final step of a walk that has path verification on. That step then reports cause 4 on a clean walk, or lets through a walk that crossed a page without paging-write. So the walks in the bench vary in depth and in where a missing paging-write sits, and each walk ends on a verification-enabled final page. A fault in the verdict register shows on the very next strobe as a wrong code or a missing strobe.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int ACC_W   = 2;
  localparam int CAUSE_W = 3;

  typedef enum logic [ACC_W-1:0] {
    ACC_RD     = 2'b00,
    ACC_SWWR   = 2'b01,
    ACC_WALKWR = 2'b10,
    ACC_FETCH  = 2'b11
  } acc_e;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE  = 3'd0,
    CZ_READ  = 3'd1,
    CZ_WRITE = 3'd2,
    CZ_EXEC  = 3'd3,
    CZ_PATH  = 3'd4
  } cause_e;

endpackage

// File: rtl/pgw_rst_sync.sv
module pgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[i] <= 1'b0;
          else         sync_q[i] <= 1'b1;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/pgw_rights_eval.sv
module pgw_rights_eval
  import pgw_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic             perm_r_i,
  input  logic             perm_w_i,
  input  logic             perm_x_i,
  input  logic             pgw_i,
  input  logic             en_pgw_i,
  output cause_e           cause_o
);

  logic walk_write_ok;

  // Walker status updates may use the paging-write bypass when enabled.
  assign walk_write_ok = perm_w_i | (en_pgw_i & pgw_i);

  always_comb begin
    cause_o = CZ_NONE;
    unique case (acc_e'(acc_i))
      ACC_RD:     if (!perm_r_i)      cause_o = CZ_READ;
      ACC_SWWR:   if (!perm_w_i)      cause_o = CZ_WRITE;
      ACC_WALKWR: if (!walk_write_ok) cause_o = CZ_WRITE;
      ACC_FETCH:  if (!perm_x_i)      cause_o = CZ_EXEC;
      default:                        cause_o = CZ_NONE;
    endcase
  end

endmodule

// File: rtl/pgw_path_track.sv
module pgw_path_track (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en_i,
  input  logic first_i,
  input  logic final_i,
  input  logic pgw_i,
  output logic path_use_o
);

  logic path_q;
  logic path_d;

  // A first step sees a clean path regardless of the previous walk.
  assign path_use_o = first_i | path_q;

  always_comb begin
    path_d = path_q;
    if (step_en_i) begin
      if (final_i) path_d = 1'b1;
      else         path_d = path_use_o & pgw_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) path_q <= 1'b1;
    else        path_q <= path_d;
  end

endmodule

// File: rtl/pgw_verdict_reg.sv
module pgw_verdict_reg
  import pgw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en_i,
  input  logic   final_i,
  input  logic   vfy_i,
  input  logic   en_vfy_i,
  input  logic   path_use_i,
  input  cause_e perm_cause_i,
  output logic   valid_o,
  output logic   allow_o,
  output cause_e cause_o
);

  logic   path_fail;
  logic   valid_d;
  logic   allow_d;
  cause_e cause_d;

  assign path_fail = final_i & vfy_i & en_vfy_i & ~path_use_i;

  always_comb begin
    valid_d = step_en_i;
    allow_d = allow_o;
    cause_d = cause_o;
    if (step_en_i) begin
      cause_d = path_fail ? CZ_PATH : perm_cause_i;
      allow_d = (cause_d == CZ_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      allow_o <= 1'b0;
      cause_o <= CZ_NONE;
    end else begin
      valid_o <= valid_d;
      allow_o <= allow_d;
      cause_o <= cause_d;
    end
  end

endmodule

// File: rtl/pgw_path_checker.sv
module pgw_path_checker
  import pgw_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               in_valid,
  input  logic               in_walk_first,
  input  logic               in_walk_final,
  input  logic [ACC_W-1:0]   in_acc,
  input  logic               in_perm_r,
  input  logic               in_perm_w,
  input  logic               in_perm_x,
  input  logic               in_pgw,
  input  logic               in_vfy,
  input  logic               en_pgw,
  input  logic               en_vfy,
  output logic               out_valid,
  output logic               out_allow,
  output logic [CAUSE_W-1:0] out_cause
);

  logic   rst_core_n;
  logic   path_use;
  cause_e perm_cause;
  cause_e cause_q;

  pgw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_core_n)
  );

  pgw_rights_eval u_rights (
    .acc_i    (in_acc),
    .perm_r_i (in_perm_r),
    .perm_w_i (in_perm_w),
    .perm_x_i (in_perm_x),
    .pgw_i    (in_pgw),
    .en_pgw_i (en_pgw),
    .cause_o  (perm_cause)
  );

  pgw_path_track u_path (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .step_en_i  (in_valid),
    .first_i    (in_walk_first),
    .final_i    (in_walk_final),
    .pgw_i      (in_pgw),
    .path_use_o (path_use)
  );

  pgw_verdict_reg u_verdict (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .step_en_i    (in_valid),
    .final_i      (in_walk_final),
    .vfy_i        (in_vfy),
    .en_vfy_i     (en_vfy),
    .path_use_i   (path_use),
    .perm_cause_i (perm_cause),
    .valid_o      (out_valid),
    .allow_o      (out_allow),
    .cause_o      (cause_q)
  );

  assign out_cause = cause_q;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_walk_final,
  input logic [1:0] in_acc,
  input logic       in_perm_r,
  input logic       in_perm_w,
  input logic       in_pgw,
  input logic       in_vfy,
  input logic       en_pgw,
  input logic       en_vfy,
  input logic       path_use,
  input logic       out_valid,
  input logic       out_allow,
  input logic [2:0] out_cause
);

  logic armed;
  logic vfail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign vfail = in_walk_final & en_vfy & in_vfy & ~path_use;

  // R1: strobe follows a step by exactly one cycle
  a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  // R1: verdict holds when no step was presented
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |-> ($stable(out_allow) && $stable(out_cause)));

  // R10: allow matches a zero cause, codes stay in range
  a_r10_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_allow == (out_cause == 3'd0)) && (out_cause <= 3'd4)));

  // R3: software write to a write-clear page
  a_r3_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && in_acc == 2'b01 && !in_perm_w && !vfail))
      |-> (out_cause == 3'd2));

  // R4: walker status write through the paging-write bypass
  a_r4_walk_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && in_acc == 2'b10 && en_pgw && in_pgw && !vfail))
      |-> out_allow);

  // R5: bypass disabled
  a_r5_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && in_acc == 2'b10 && !en_pgw && !in_perm_w && !vfail))
      |-> (out_cause == 3'd2));

  // R7 and R9: path failure reported with top priority
  a_r9_path_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && vfail)) |-> (out_cause == 3'd4));

  // R8: verification disabled never produces a path cause
  a_r8_vfy_off: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && !en_vfy && in_acc == 2'b00 && in_perm_r)) |-> out_allow);

endmodule

bind pgw_path_checker pgw_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .in_valid      (in_valid),
  .in_walk_final (in_walk_final),
  .in_acc        (in_acc),
  .in_perm_r     (in_perm_r),
  .in_perm_w     (in_perm_w),
  .in_pgw        (in_pgw),
  .in_vfy        (in_vfy),
  .en_pgw        (en_pgw),
  .en_vfy        (en_vfy),
  .path_use      (path_use),
  .out_valid     (out_valid),
  .out_allow     (out_allow),
  .out_cause     (out_cause)
);

// File: tb/sim_pgw_path_checker.sv
`timescale 1ns/1ps
module sim_pgw_path_checker;

  logic       clk;
  logic       arst_n;
  logic       in_valid, in_walk_first, in_walk_final;
  logic [1:0] in_acc;
  logic       in_perm_r, in_perm_w, in_perm_x, in_pgw, in_vfy;
  logic       en_pgw, en_vfy;
  logic       out_valid, out_allow;
  logic [2:0] out_cause;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  bit  path_m = 1'b1;

  pgw_path_checker u0 (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid),
    .in_walk_first(in_walk_first), .in_walk_final(in_walk_final),
    .in_acc(in_acc), .in_perm_r(in_perm_r), .in_perm_w(in_perm_w),
    .in_perm_x(in_perm_x), .in_pgw(in_pgw), .in_vfy(in_vfy),
    .en_pgw(en_pgw), .en_vfy(en_vfy), .out_valid(out_valid),
    .out_allow(out_allow), .out_cause(out_cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [2:0] rights_cause(input logic [1:0] acc,
      input logic r, input logic w, input logic x, input logic pw, input logic enp);
    case (acc)
      2'b00:   return r ? 3'd0 : 3'd1;
      2'b01:   return w ? 3'd0 : 3'd2;
      2'b10:   return (w || (pw && enp)) ? 3'd0 : 3'd2;
      default: return x ? 3'd0 : 3'd3;
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid/allow/cause=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic first, input logic fin, input logic [1:0] acc,
      input logic r, input logic w, input logic x, input logic pw, input logic vf,
      input logic enp, input logic env, input string req);
    logic       use_p;
    logic [2:0] ec;
    use_p = first | path_m;
    ec = (fin && env && vf && !use_p) ? 3'd4 : rights_cause(acc, r, w, x, pw, enp);
    path_m = fin ? 1'b1 : (use_p & pw);
    in_valid = 1'b1; in_walk_first = first; in_walk_final = fin; in_acc = acc;
    in_perm_r = r; in_perm_w = w; in_perm_x = x; in_pgw = pw; in_vfy = vf;
    en_pgw = enp; en_vfy = env;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_allow, out_cause}, {1'b1, (ec == 3'd0), ec});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    int unsigned rv;
    arst_n = 1'b0;
    in_valid = 1'b1; in_walk_first = 0; in_walk_final = 0; in_acc = 2'b00;
    in_perm_r = 0; in_perm_w = 0; in_perm_x = 0; in_pgw = 0; in_vfy = 0;
    en_pgw = 0; en_vfy = 0;
    repeat (3) @(negedge clk);
    // R11: outputs zero while reset is asserted even with a step presented
    check("R11", {out_valid, out_allow, out_cause}, 5'b0);
    in_valid = 1'b0;
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", {out_valid, out_allow, out_cause}, 5'b0);

    // R11: path flag clean after reset; final verified page with no first marker
    step(0, 1, 2'b00, 1, 0, 0, 0, 1, 1, 1, "R11 path clean");
    // R2
    step(1, 1, 2'b00, 0, 1, 1, 1, 0, 1, 1, "R2 read denied");
    step(1, 1, 2'b11, 1, 1, 0, 1, 0, 1, 1, "R2 fetch denied");
    step(1, 1, 2'b11, 0, 0, 1, 0, 0, 1, 1, "R2 fetch ok");
    // R3
    step(0, 0, 2'b01, 1, 0, 1, 1, 0, 1, 1, "R3 sw write on pgw page");
    // R4
    step(1, 0, 2'b10, 1, 0, 0, 1, 0, 1, 1, "R4 walker write via pgw");
    step(0, 0, 2'b10, 1, 0, 0, 0, 0, 1, 1, "R4 walker write no pgw");
    step(0, 1, 2'b10, 0, 1, 0, 0, 0, 1, 1, "R4 walker write w set");
    // R5
    step(1, 0, 2'b10, 1, 0, 0, 1, 0, 0, 1, "R5 bypass disabled");
    step(0, 1, 2'b00, 1, 0, 0, 1, 0, 0, 1, "R5 end walk");
    // R6 / R7: clean three-level walk
    step(1, 0, 2'b00, 1, 0, 0, 1, 0, 1, 1, "R6 walk a1");
    step(0, 0, 2'b10, 1, 0, 0, 1, 0, 1, 1, "R6 walk a2");
    step(0, 1, 2'b00, 1, 0, 0, 0, 1, 1, 1, "R7 clean path allowed");
    // R7: middle page lacks paging-write
    step(1, 0, 2'b00, 1, 0, 0, 1, 0, 1, 1, "R6 walk b1");
    step(0, 0, 2'b00, 1, 0, 0, 0, 0, 1, 1, "R6 walk b2");
    step(0, 0, 2'b00, 1, 0, 0, 1, 0, 1, 1, "R6 walk b3");
    step(0, 1, 2'b00, 1, 0, 0, 0, 1, 1, 1, "R7 broken path denied");
    // R6: new walk restarts the flag
    step(1, 0, 2'b00, 1, 0, 0, 0, 0, 1, 1, "R6 walk c1");
    step(1, 0, 2'b00, 1, 0, 0, 1, 0, 1, 1, "R6 restart");
    step(0, 1, 2'b00, 1, 0, 0, 0, 1, 1, 1, "R6 restart allowed");
    // R8
    step(1, 0, 2'b00, 1, 0, 0, 0, 0, 1, 0, "R8 walk d1");
    step(0, 1, 2'b00, 1, 0, 0, 0, 1, 1, 0, "R8 vfy off ignored");
    // R9
    step(1, 0, 2'b00, 1, 0, 0, 0, 0, 1, 1, "R9 walk e1");
    step(0, 1, 2'b11, 1, 0, 0, 0, 1, 1, 1, "R9 path over exec");
    // R1: idle cycle, strobe low and verdict held
    held = {1'b1, out_allow, out_cause};
    @(negedge clk);
    check("R1 idle", {out_valid, out_allow, out_cause}, {1'b0, held[3:0]});
    // R10: cause/allow consistency is part of every compare; randomized mix
    rv = $urandom(32'h5eed_1234);
    for (int i = 0; i < 1500; i++) begin
      rv = $urandom;
      step(rv[0] & rv[1], rv[2] & rv[3], rv[5:4], rv[6], rv[7], rv[8], rv[9] | rv[10],
           rv[11], rv[12] | rv[13], rv[14] | rv[15], "R10 random");
      if (rv[16] & rv[17]) begin
        held = {1'b1, out_allow, out_cause};
        @(negedge clk);
        check("R1 random idle", {out_valid, out_allow, out_cause}, {1'b0, held[3:0]});
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule